// File: doc/BRIEF.md
# Shared-Bus Packet Link Controller

This block frames whole packets on a two-wire shared bus. One wire carries the serial bytes and the other is an open-drain attention wire that a sender holds low for the length of its packet. Bit timing is left to an external byte transmitter and an external byte receiver. This block decides which bytes move, in what order, and when the attention wire is held.

A packet is a destination byte, a length byte L, L payload bytes and one check byte, which gives L+3 bytes in all. To send, the block first looks at the attention wire with its own driver off. If the wire is already low, the send fails at once. If it is high, the block pulls it low, lets at least two bit periods pass, and then fetches the bytes one by one from a synchronous-read buffer. It reads the length from buffer address 1 and sends from address 0 upward.

To receive, the block asks the receiver for one byte at a time. It filters the destination byte, checks the length against a limit, and writes every accepted byte to a buffer port starting at address 0. The check byte is stored as it arrives and is neither computed nor verified here. Each operation ends with a one-cycle `done` pulse and a status code.

Top module: `pkt_link_ctrl`

## Requirements
- R1: After reset, `attn_pull`, `busy`, `done`, `btx_start`, `brx_start` and `wr_en` are all low.
- R2: A `tx_start` while idle with `attn_in` low ends in the next cycle with `done` and status 1 (bus busy). No byte is sent and `attn_pull` is never raised.
- R3: A `tx_start` while idle with `attn_in` high raises `attn_pull` in the next cycle. The first `btx_start` comes no sooner than 2·BIT_CYC cycles after that.
- R4: A send reads the length L from buffer address 1. It then presents buffer bytes 0 through L+2 on `btx_data`, in address order, one per `btx_start`.
- R5: When every byte is acknowledged with `btx_ok` high, `done` pulses with status 0 (ok), and `attn_pull` falls in the same cycle as `done`.
- R6: A byte acknowledged with `btx_ok` low ends the send at once with status 2 (collision). No further byte is started, and `attn_pull` is released with `done`.
- R7: A received destination byte equal to `own_addr` or to 0xFF is accepted and written to buffer address 0.
- R8: Any other destination byte ends reception with status 3 (not addressed here), and no buffer write is made.
- R9: With ACCEPT_ALL set, every destination value is accepted.
- R10: A received length byte that is not below MAX_LEN is written to address 1, and reception then ends with status 5 (length error). MAX_LEN-1 is accepted.
- R11: After an accepted length L, exactly L+1 more bytes are received and written to addresses 2 through L+2. Reception then ends with status 0.
- R12: A byte delivered with `brx_ok` low, at any position in the packet, ends reception with status 4 (I/O error), and no write is made for that byte.
- R13: While `busy` is high, `tx_start` and `rx_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| own_addr | input | 8 | Node address used by the receive filter |
| tx_start | input | 1 | Start sending the packet held in the transmit buffer |
| rx_start | input | 1 | Start receiving a packet |
| attn_in | input | 1 | Sampled level of the attention wire |
| attn_pull | output | 1 | Pull the attention wire low |
| btx_start | output | 1 | One-cycle start strobe to the byte transmitter |
| btx_data | output | 8 | Byte to send, valid with `btx_start` |
| btx_done | input | 1 | Byte transmitter finished its byte |
| btx_ok | input | 1 | Byte sent without collision, valid with `btx_done` |
| rd_addr | output | BUF_AW | Transmit buffer read address |
| rd_data | input | 8 | Transmit buffer data, one cycle after the address |
| brx_start | output | 1 | One-cycle request to the byte receiver |
| brx_done | input | 1 | Byte receiver finished its byte |
| brx_ok | input | 1 | Byte framed correctly, valid with `brx_done` |
| brx_data | input | 8 | Received byte, valid with `brx_done` |
| wr_en | output | 1 | Receive buffer write strobe |
| wr_addr | output | BUF_AW | Receive buffer write address |
| wr_data | output | 8 | Receive buffer write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 3 | Result code, valid with `done` |

## Verification
The assertions assume three things about the byte engines: each returns exactly one `btx_done` or `brx_done` per start strobe, never returns one unasked, and the transmit buffer answers a read one cycle after the address. The bench models both engines and the buffer so that they follow this rule: a reply is given only after the matching strobe has been seen, with a fixed delay of a few cycles. The attention level is held steady for a whole operation, and starts are issued only while the block is idle, except in the one test that pokes `rx_start` during a send on purpose.

// File: rtl/pkt_link_ctrl.sv
module pkt_link_ctrl #(
  parameter int MAX_LEN    = 16,
  parameter int BIT_CYC    = 8,
  parameter bit ACCEPT_ALL = 1'b0,
  parameter int BUF_AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        own_addr,
  input  logic              tx_start,
  input  logic              rx_start,
  input  logic              attn_in,
  output logic              attn_pull,
  output logic              btx_start,
  output logic [7:0]        btx_data,
  input  logic              btx_done,
  input  logic              btx_ok,
  output logic [BUF_AW-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              brx_start,
  input  logic              brx_done,
  input  logic              brx_ok,
  input  logic [7:0]        brx_data,
  output logic              wr_en,
  output logic [BUF_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status
);
  localparam int GAP_CYC = 2 * BIT_CYC;
  localparam int CW      = $clog2(GAP_CYC + 4) + 1;
  localparam logic [2:0] ST_OK = 3'd0, ST_BUSY = 3'd1, ST_COLL = 3'd2,
                         ST_NFM = 3'd3, ST_IO = 3'd4, ST_DATA = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_LEN_RD, S_LEN_LAT, S_RD, S_GO, S_TXW, S_RXGO, S_RXW
  } state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic [BUF_AW-1:0] idx, last;
  logic [1:0]        stage;

  wire dst_ok  = ACCEPT_ALL || (brx_data == own_addr) || (brx_data == 8'hFF);
  wire len_bad = int'(brx_data) >= MAX_LEN;

  assign busy      = (st != S_IDLE);
  assign btx_start = (st == S_GO);
  assign btx_data  = rd_data;
  assign brx_start = (st == S_RXGO);
  assign rd_addr   = (st == S_LEN_RD) ? BUF_AW'(1) : idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; last <= '0; stage <= 2'd0;
      attn_pull <= 1'b0; done <= 1'b0; status <= ST_OK;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= 8'd0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (tx_start) begin
            if (!attn_in) begin
              done <= 1'b1; status <= ST_BUSY;
            end else begin
              attn_pull <= 1'b1; cnt <= CW'(GAP_CYC - 1); st <= S_GAP;
            end
          end else if (rx_start) begin
            stage <= 2'd0; st <= S_RXGO;
          end
        end
        S_GAP:     if (cnt == '0) st <= S_LEN_RD; else cnt <= cnt - 1'b1;
        S_LEN_RD:  st <= S_LEN_LAT;
        S_LEN_LAT: begin last <= BUF_AW'(rd_data) + BUF_AW'(2); st <= S_RD; end
        S_RD:      st <= S_GO;
        S_GO:      st <= S_TXW;
        S_TXW: if (btx_done) begin
          if (!btx_ok) begin
            st <= S_IDLE; attn_pull <= 1'b0; done <= 1'b1; status <= ST_COLL;
          end else if (idx == last) begin
            st <= S_IDLE; attn_pull <= 1'b0; done <= 1'b1; status <= ST_OK;
          end else begin
            idx <= idx + 1'b1; st <= S_RD;
          end
        end
        S_RXGO: st <= S_RXW;
        S_RXW: if (brx_done) begin
          wr_addr <= idx;
          wr_data <= brx_data;
          if (!brx_ok) begin
            st <= S_IDLE; done <= 1'b1; status <= ST_IO;
          end else begin
            case (stage)
              2'd0: if (dst_ok) begin
                wr_en <= 1'b1; idx <= idx + 1'b1; stage <= 2'd1; st <= S_RXGO;
              end else begin
                st <= S_IDLE; done <= 1'b1; status <= ST_NFM;
              end
              2'd1: begin
                wr_en <= 1'b1;
                if (len_bad) begin
                  st <= S_IDLE; done <= 1'b1; status <= ST_DATA;
                end else begin
                  last <= idx + 1'b1 + BUF_AW'(brx_data);
                  idx <= idx + 1'b1; stage <= 2'd2; st <= S_RXGO;
                end
              end
              default: begin
                wr_en <= 1'b1;
                if (idx == last) begin
                  st <= S_IDLE; done <= 1'b1; status <= ST_OK;
                end else begin
                  idx <= idx + 1'b1; st <= S_RXGO;
                end
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hold_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !attn_pull) hold_cnt <= '0;
    else if (hold_cnt != '1) hold_cnt <= hold_cnt + 1'b1;
  end

  // R3
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btx_start |-> (hold_cnt >= CW'(GAP_CYC)));
  // R6
  attn_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btx_start |-> attn_pull);
  // R5
  attn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attn_pull) |-> done);
  // R2
  busy_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_start && !attn_in) |=> (done && status == ST_BUSY && !attn_pull));
  // R8
  nfm_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_NFM) |-> !wr_en);
  // R13
  write_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |-> busy);
endmodule

// File: tb/pkt_link_ctrl_tb_top.sv
module pkt_link_ctrl_tb_top;
  localparam int MAXL = 6, BC = 3, AW = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] own_addr = 8'h2A;
  logic tx_start = 0, rx_start_i = 0, rx_start_a = 0, attn_in = 1;
  logic btx_done = 0, btx_ok = 1, brx_done = 0, brx_ok = 1;
  logic [7:0] brx_data = 0, rd_data = 0;
  logic i_attn, i_btx_start, i_brx_start, i_wr_en, i_busy, i_done;
  logic [7:0] i_btx_data, i_wr_data; logic [AW-1:0] i_rd_addr, i_wr_addr; logic [2:0] i_status;
  logic a_attn, a_btx_start, a_brx_start, a_wr_en, a_busy, a_done;
  logic [7:0] a_btx_data, a_wr_data; logic [AW-1:0] a_rd_addr, a_wr_addr; logic [2:0] a_status;

  pkt_link_ctrl #(.MAX_LEN(MAXL), .BIT_CYC(BC), .ACCEPT_ALL(1'b0), .BUF_AW(AW)) dut_i (
    .clk, .rst_n, .own_addr, .tx_start, .rx_start(rx_start_i), .attn_in, .attn_pull(i_attn),
    .btx_start(i_btx_start), .btx_data(i_btx_data), .btx_done, .btx_ok,
    .rd_addr(i_rd_addr), .rd_data, .brx_start(i_brx_start), .brx_done, .brx_ok, .brx_data,
    .wr_en(i_wr_en), .wr_addr(i_wr_addr), .wr_data(i_wr_data), .busy(i_busy), .done(i_done), .status(i_status));

  pkt_link_ctrl #(.MAX_LEN(MAXL), .BIT_CYC(BC), .ACCEPT_ALL(1'b1), .BUF_AW(AW)) dut_all (
    .clk, .rst_n, .own_addr, .tx_start(1'b0), .rx_start(rx_start_a), .attn_in, .attn_pull(a_attn),
    .btx_start(a_btx_start), .btx_data(a_btx_data), .btx_done(1'b0), .btx_ok(1'b1),
    .rd_addr(a_rd_addr), .rd_data, .brx_start(a_brx_start), .brx_done, .brx_ok, .brx_data,
    .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data), .busy(a_busy), .done(a_done), .status(a_status));

  logic [7:0] tmem [0:511];
  logic [7:0] rmem [0:511];
  logic [7:0] rx_q [0:511];
  int wcount = 0, attn_cnt = 0, brx_cnt = 0, cyc = 0;
  int checks = 0, errors = 0;

  always_ff @(posedge clk) begin
    rd_data <= tmem[i_rd_addr];
    cyc <= cyc + 1;
    if (i_attn) attn_cnt <= attn_cnt + 1;
    if (i_brx_start) brx_cnt <= brx_cnt + 1;
    if (i_wr_en) begin rmem[i_wr_addr] <= i_wr_data; wcount <= wcount + 1; end
    else if (a_wr_en) begin rmem[a_wr_addr] <= a_wr_data; wcount <= wcount + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  int r_status, r_sent, r_gap, r_attn_done, r_attn_first;
  logic [7:0] sent [0:511];

  task automatic run_tx(input int len, input int fail_at, input bit poke);
    int guard = 0, t0; bit fin = 0;
    tmem[0] = 8'h5C; tmem[1] = 8'(len);
    for (int k = 2; k < 300; k++) tmem[k] = 8'(k * 37 + len);
    r_sent = 0; r_gap = -1; r_status = -1;
    @(negedge clk); tx_start = 1; t0 = cyc;
    @(negedge clk); tx_start = 0; r_attn_first = i_attn;
    while (!fin && guard < 3000) begin
      if (i_done) begin fin = 1; r_status = i_status; r_attn_done = i_attn; end
      else if (i_btx_start) begin
        sent[r_sent] = i_btx_data;
        if (r_sent == 0) r_gap = cyc - t0;
        r_sent++;
        if (poke && r_sent == 1) rx_start_i = 1;
        @(negedge clk); rx_start_i = 0;
        @(negedge clk); btx_done = 1; btx_ok = (r_sent - 1 != fail_at);
        @(negedge clk); btx_done = 0; btx_ok = 1;
      end else @(negedge clk);
      guard++;
    end
    if (!fin) chk(0, "tx timeout", 0, 1);
  endtask

  task automatic run_rx(input bit sel, input int nbytes, input int fail_at);
    int guard = 0, nb = 0; bit fin = 0;
    r_status = -1;
    @(negedge clk); if (sel) rx_start_a = 1; else rx_start_i = 1;
    @(negedge clk); rx_start_a = 0; rx_start_i = 0;
    while (!fin && guard < 3000) begin
      if (sel ? a_done : i_done) begin fin = 1; r_status = sel ? a_status : i_status; end
      else if (sel ? a_brx_start : i_brx_start) begin
        @(negedge clk); brx_done = 1; brx_ok = (nb != fail_at); brx_data = rx_q[nb]; nb++;
        @(negedge clk); brx_done = 0; brx_ok = 1;
      end else @(negedge clk);
      guard++;
    end
    if (!fin) chk(0, "rx timeout", 0, 1);
    r_sent = nb;
  endtask

  function automatic void fill_rx(input logic [7:0] dst, input int len);
    rx_q[0] = dst; rx_q[1] = 8'(len);
    for (int k = 2; k < 300; k++) rx_q[k] = 8'(k * 11 + len + 3);
  endfunction

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0, a0, b0;
    repeat (4) @(negedge clk);
    // R1
    chk(!i_attn && !i_busy && !i_done && !i_btx_start && !i_brx_start && !i_wr_en, "R1 reset outputs", 1, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!i_attn && !i_busy && !i_done && !i_wr_en, "R1 after reset", int'(i_busy), 0);

    for (int len = 0; len <= 5; len++) begin
      run_tx(len, -1, 0);
      chk(r_attn_first == 1, "R3 attn pulled", r_attn_first, 1);
      chk(r_gap >= 2 * BC + 1, "R3 gap", r_gap, 2 * BC + 1);
      chk(r_sent == len + 3, "R4 byte count", r_sent, len + 3);
      for (int k = 0; k < len + 3; k++)
        if (sent[k] != tmem[k]) chk(0, "R4 byte value", sent[k], tmem[k]);
      chk(r_status == 0, "R5 status ok", r_status, 0);
      chk(r_attn_done == 0, "R5 attn released", r_attn_done, 0);
    end

    attn_in = 0; a0 = attn_cnt;
    run_tx(3, -1, 0);
    chk(r_status == 1, "R2 busy status", r_status, 1);
    chk(r_sent == 0, "R2 nothing sent", r_sent, 0);
    chk(attn_cnt == a0, "R2 attn untouched", attn_cnt - a0, 0);
    attn_in = 1;

    for (int f = 0; f < 5; f++) begin
      run_tx(2, f, 0);
      chk(r_status == 2, "R6 collision status", r_status, 2);
      chk(r_sent == f + 1, "R6 stops after failing byte", r_sent, f + 1);
      chk(r_attn_done == 0, "R6 attn released", r_attn_done, 0);
    end

    w0 = wcount; b0 = brx_cnt;
    run_tx(1, -1, 1);
    repeat (3) @(negedge clk);
    chk(r_status == 0 && r_sent == 4, "R13 tx unaffected by rx_start", r_sent, 4);
    chk(brx_cnt == b0 && wcount == w0, "R13 rx_start ignored", brx_cnt - b0, 0);

    for (int len = 0; len < MAXL; len++) begin
      for (int d = 0; d < 2; d++) begin
        fill_rx(d ? 8'hFF : own_addr, len); w0 = wcount;
        run_rx(0, len + 3, -1);
        @(negedge clk);
        chk(r_status == 0, "R11 rx status ok", r_status, 0);
        chk(wcount - w0 == len + 3, "R11 write count", wcount - w0, len + 3);
        chk(rmem[0] == rx_q[0], "R7 dest stored", rmem[0], rx_q[0]);
        for (int k = 1; k < len + 3; k++)
          if (rmem[k] != rx_q[k]) chk(0, "R11 stored byte", rmem[k], rx_q[k]);
      end
    end

    foreach (rx_q[k]) if (k < 1) begin end
    for (int d = 0; d < 4; d++) begin
      logic [7:0] dv;
      dv = (d == 0) ? 8'h00 : (d == 1) ? 8'h2B : (d == 2) ? 8'hFE : 8'h29;
      fill_rx(dv, 2); w0 = wcount;
      run_rx(0, 5, -1);
      @(negedge clk);
      chk(r_status == 3, "R8 not-for-me status", r_status, 3);
      chk(wcount == w0, "R8 no write", wcount - w0, 0);
      fill_rx(dv, 2); w0 = wcount;
      run_rx(1, 5, -1);
      @(negedge clk);
      chk(r_status == 0, "R9 accept-all status", r_status, 0);
      chk(wcount - w0 == 5 && rmem[0] == dv, "R9 accept-all writes", wcount - w0, 5);
    end

    for (int t = 0; t < 3; t++) begin
      int lv;
      lv = (t == 0) ? MAXL : (t == 1) ? MAXL + 1 : 255;
      fill_rx(own_addr, lv); w0 = wcount;
      run_rx(0, 2, -1);
      @(negedge clk);
      chk(r_status == 5, "R10 length error", r_status, 5);
      chk(wcount - w0 == 2 && rmem[1] == 8'(lv), "R10 length stored", wcount - w0, 2);
    end

    for (int f = 0; f < 5; f++) begin
      fill_rx(own_addr, 2); w0 = wcount;
      run_rx(0, 5, f);
      @(negedge clk);
      chk(r_status == 4, "R12 io error", r_status, 4);
      chk(wcount - w0 == f, "R12 writes before failure", wcount - w0, f);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule